// File: doc/BRIEF.md
# Multithreaded Reorder Buffer with Squash Walker

This block keeps the in-flight instructions of several hardware threads in program order. Each thread owns a circular queue of entries, and every entry carries a sequence number, a PC, a ready bit and a squashed bit. Dispatch appends to the tail of a thread's queue. Completion marks entries ready by sequence number. Commit retires a thread's oldest entry once it is ready, and the retired entry's sequence number, PC and squashed flag appear on the retire outputs in the same cycle.

A squash request names a thread and a sequence number. It starts a walk at that thread's youngest entry and moves toward the head. Each cycle the walk marks at most a fixed number of entries. Every entry younger than the request is flagged as squashed and made ready, and stays in the queue until normal commit drains it. The block also reports, across all threads, the oldest head and the youngest tail. Both are chosen by comparing sequence numbers.

Top module: `thread_rob`

## Requirements
- R1: After reset every queue is empty: `tot_cnt` is 0, `ghead_vld`, `gtail_vld`, `can_cmt`, `ret_vld`, `head_rdy` and `thr_busy` are all 0.
- R2: An insert on `ins_tid` that is accepted appends the entry at that thread's tail, and `tot_cnt` rises by one at the next clock edge.
- R3: An insert is dropped with no effect on any output when its thread holds DEPTH entries, when its thread's walk is in progress (`thr_busy` set), or when a squash for the same thread is requested in the same cycle.
- R4: A completion (`cpl_vld`, `cpl_tid`, `cpl_seq`) sets the ready bit of the valid entry of that thread whose sequence number equals `cpl_seq`. `head_rdy[t]` is 1 only when thread t is non-empty and its head is ready. `can_cmt` is the OR of `head_rdy`.
- R5: With `cmt_vld` set, the head of `cmt_tid` retires in that cycle only if it is ready. `ret_vld`, `ret_seq` and `ret_pc` show the retired entry combinationally, and `tot_cnt` falls by one at the edge. A commit on a thread whose head is not ready has no effect.
- R6: A squash request made while `tot_cnt` is 0 is ignored, and `thr_busy` stays 0. Otherwise the squash captures `sq_seq`, and `thr_busy` of that thread rises at the next edge if the thread still holds entries.
- R7: In each cycle after the request the walk marks at most SQ_W entries, youngest first. A marked entry has a sequence number greater than the squash number, becomes ready, and retires with `ret_sq` = 1.
- R8: The walk ends, and `thr_busy` falls, at the edge of the first cycle in which it meets an entry whose sequence number is not greater than the squash number, or moves past the head. Such older entries keep `ret_sq` = 0 and their ready state.
- R9: `ghead_tid`/`ghead_seq` name the non-empty thread whose head has the lowest sequence number (a tie goes to the lower thread number). `gtail_tid`/`gtail_seq` name the thread whose tail has the highest sequence number. `ghead_vld` and `gtail_vld` are 0 exactly when all queues are empty.
- R10: All sequence-number comparisons are unsigned over SEQ_W bits. With SEQ_W = 8, the value 200 ranks younger than 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_vld | input | 1 | Insert request |
| ins_tid | input | TID_W | Thread of the insert |
| ins_seq | input | SEQ_W | Sequence number of the inserted entry |
| ins_pc | input | PC_W | PC of the inserted entry |
| cpl_vld | input | 1 | Completion request |
| cpl_tid | input | TID_W | Thread of the completion |
| cpl_seq | input | SEQ_W | Sequence number being completed |
| cmt_vld | input | 1 | Commit request |
| cmt_tid | input | TID_W | Thread whose head should retire |
| sq_vld | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread to squash |
| sq_seq | input | SEQ_W | Entries younger than this are squashed |
| tot_cnt | output | TOT_W | Entries held across all threads |
| thr_full | output | NTHR | Per-thread queue full |
| thr_busy | output | NTHR | Per-thread squash walk in progress |
| head_rdy | output | NTHR | Per-thread head present and ready |
| can_cmt | output | 1 | Some thread's head may retire |
| ret_vld | output | 1 | An entry retires this cycle |
| ret_seq | output | SEQ_W | Sequence number of the retiring entry |
| ret_pc | output | PC_W | PC of the retiring entry |
| ret_sq | output | 1 | Retiring entry was squashed |
| ghead_vld | output | 1 | Global head valid |
| ghead_tid | output | TID_W | Thread of the global head |
| ghead_seq | output | SEQ_W | Sequence number of the global head |
| gtail_vld | output | 1 | Global tail valid |
| gtail_tid | output | TID_W | Thread of the global tail |
| gtail_seq | output | SEQ_W | Sequence number of the global tail |

## Verification
The internal state that can go wrong is mostly hidden in the walk: the walk pointer, the captured squash number and the per-entry flags. A walk pointer that is off by one, or a comparison that is wrong, marks the wrong set of entries. That shows up only when those entries drain, as a wrong `ret_sq` value on the retire outputs, possibly many cycles later. So the scoreboard compares every retired entry's sequence number, PC and squashed flag in order. A walk that covers too many or too few entries per cycle shows at once in the `thr_busy` timing, which the bench samples edge by edge. A wrong count or wrong queue pointers shows up within one cycle in `tot_cnt` and in the global head and tail selection.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Classification of one slot visited by the squash walk.
  typedef enum logic [1:0] {
    STEP_MARK = 2'd0,  // younger than the squash number: mark it
    STEP_STOP = 2'd1,  // not younger: walk finishes
    STEP_OUT  = 2'd2   // beyond the head of the queue: walk finishes
  } walk_step_e;

  // Slot index k places before p in a ring of the given depth.
  function automatic int ring_back(int p, int k, int depth);
    return ((p - k) % depth + depth) % depth;
  endfunction

  // Slot index one place after p.
  function automatic int ring_next(int p, int depth);
    return (p + 1) % depth;
  endfunction

  // Number of steps from slot a forward to slot b.
  function automatic int ring_gap(int a, int b, int depth);
    return ((b - a) % depth + depth) % depth;
  endfunction

endpackage

// File: rtl/rob_tq.sv
module rob_tq
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  parameter int SQ_W  = 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int WN_W  = $clog2(SQ_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic [PC_W-1:0]  ins_pc,
  input  logic             cpl_en,
  input  logic [SEQ_W-1:0] cpl_seq,
  input  logic             cmt_en,
  input  logic             sq_en,
  input  logic [SEQ_W-1:0] sq_seq,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic             busy,
  output logic             ins_acc,
  output logic             ret,
  output logic             hd_rdy,
  output logic [SEQ_W-1:0] hd_seq,
  output logic [PC_W-1:0]  hd_pc,
  output logic             hd_sq,
  output logic [SEQ_W-1:0] tl_seq,
  output logic [WN_W-1:0]  walk_n,
  output logic             walk_end
);

  logic [DEPTH-1:0] vld_q, rdy_q, sq_q, mark;
  logic [SEQ_W-1:0] seq_q [DEPTH];
  logic [PC_W-1:0]  pc_q  [DEPTH];
  logic [PTR_W-1:0] hd_q, tl_q, wp_q;
  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             busy_q;
  logic [SEQ_W-1:0] sqs_q;

  assign cnt     = cnt_q;
  assign busy    = busy_q;
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign ins_acc = ins_en && !full && !busy_q && !sq_en;
  assign hd_rdy  = (cnt_q != '0) && rdy_q[hd_q];
  assign ret     = cmt_en && hd_rdy;
  assign hd_seq  = seq_q[hd_q];
  assign hd_pc   = pc_q[hd_q];
  assign hd_sq   = sq_q[hd_q];
  assign tl_seq  = seq_q[PTR_W'(ring_back(int'(tl_q), 1, DEPTH))];
  assign cnt_nx  = cnt_q + CNT_W'(ins_acc) - CNT_W'(ret);

  // Walk step: look at SQ_W+1 slots back from the walk pointer; mark the
  // leading run of younger entries (up to SQ_W), finish if the run breaks.
  always_comb begin
    int         span;
    int         idx;
    logic       run;
    walk_step_e st;
    mark   = '0;
    walk_n = '0;
    run    = 1'b1;
    span   = ring_gap(int'(hd_q), int'(wp_q), DEPTH) + 1;
    for (int k = 0; k <= SQ_W; k++) begin
      idx = ring_back(int'(wp_q), k, DEPTH);
      if (k >= span || !vld_q[PTR_W'(idx)])        st = STEP_OUT;
      else if (seq_q[PTR_W'(idx)] > sqs_q)         st = STEP_MARK;
      else                                         st = STEP_STOP;
      if (st != STEP_MARK) run = 1'b0;
      if (run && busy_q && k < SQ_W) begin
        mark[PTR_W'(idx)] = 1'b1;
        walk_n            = walk_n + WN_W'(1);
      end
    end
    walk_end = busy_q && !run;
  end

  always_ff @(posedge clk) begin
    if (ins_acc) begin
      seq_q[tl_q] <= ins_seq;
      pc_q[tl_q]  <= ins_pc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      rdy_q  <= '0;
      sq_q   <= '0;
      hd_q   <= '0;
      tl_q   <= '0;
      wp_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      sqs_q  <= '0;
    end else begin
      if (cpl_en) begin
        for (int i = 0; i < DEPTH; i++)
          if (vld_q[i] && seq_q[i] == cpl_seq) rdy_q[i] <= 1'b1;
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (mark[i]) begin
          rdy_q[i] <= 1'b1;
          sq_q[i]  <= 1'b1;
        end
      end
      if (ins_acc) begin
        vld_q[tl_q] <= 1'b1;
        rdy_q[tl_q] <= 1'b0;
        sq_q[tl_q]  <= 1'b0;
        tl_q        <= PTR_W'(ring_next(int'(tl_q), DEPTH));
      end
      if (ret) begin
        vld_q[hd_q] <= 1'b0;
        hd_q        <= PTR_W'(ring_next(int'(hd_q), DEPTH));
      end
      cnt_q <= cnt_nx;
      if (sq_en) begin
        busy_q <= (cnt_nx != '0);
        wp_q   <= PTR_W'(ring_back(int'(tl_q), 1, DEPTH));
        sqs_q  <= sq_seq;
      end else if (walk_end) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        wp_q <= PTR_W'(ring_back(int'(wp_q), int'(walk_n), DEPTH));
      end
    end
  end

endmodule

// File: rtl/rob_pick.sv
module rob_pick #(
  parameter int NTHR  = 2,
  parameter int SEQ_W = 16,
  parameter int TID_W = 1
) (
  input  logic [NTHR-1:0]             ne,
  input  logic [NTHR-1:0][SEQ_W-1:0]  hseq,
  input  logic [NTHR-1:0][SEQ_W-1:0]  tseq,
  output logic                        h_vld,
  output logic [TID_W-1:0]            h_tid,
  output logic [SEQ_W-1:0]            h_seq,
  output logic                        t_vld,
  output logic [TID_W-1:0]            t_tid,
  output logic [SEQ_W-1:0]            t_seq
);

  // Strict comparisons keep the lower thread number on a tie.
  always_comb begin
    h_vld = 1'b0; h_tid = '0; h_seq = '0;
    t_vld = 1'b0; t_tid = '0; t_seq = '0;
    for (int t = 0; t < NTHR; t++) begin
      if (ne[t]) begin
        if (!h_vld || hseq[t] < h_seq) begin
          h_vld = 1'b1; h_tid = TID_W'(t); h_seq = hseq[t];
        end
        if (!t_vld || tseq[t] > t_seq) begin
          t_vld = 1'b1; t_tid = TID_W'(t); t_seq = tseq[t];
        end
      end
    end
  end

endmodule

// File: rtl/thread_rob.sv
module thread_rob #(
  parameter int NTHR  = 2,
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  parameter int PC_W  = 32,
  parameter int SQ_W  = 2,
  localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int TOT_W = $clog2(NTHR * DEPTH + 1),
  localparam int WN_W  = $clog2(SQ_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_vld,
  input  logic [TID_W-1:0] ins_tid,
  input  logic [SEQ_W-1:0] ins_seq,
  input  logic [PC_W-1:0]  ins_pc,
  input  logic             cpl_vld,
  input  logic [TID_W-1:0] cpl_tid,
  input  logic [SEQ_W-1:0] cpl_seq,
  input  logic             cmt_vld,
  input  logic [TID_W-1:0] cmt_tid,
  input  logic             sq_vld,
  input  logic [TID_W-1:0] sq_tid,
  input  logic [SEQ_W-1:0] sq_seq,
  output logic [TOT_W-1:0] tot_cnt,
  output logic [NTHR-1:0]  thr_full,
  output logic [NTHR-1:0]  thr_busy,
  output logic [NTHR-1:0]  head_rdy,
  output logic             can_cmt,
  output logic             ret_vld,
  output logic [SEQ_W-1:0] ret_seq,
  output logic [PC_W-1:0]  ret_pc,
  output logic             ret_sq,
  output logic             ghead_vld,
  output logic [TID_W-1:0] ghead_tid,
  output logic [SEQ_W-1:0] ghead_seq,
  output logic             gtail_vld,
  output logic [TID_W-1:0] gtail_tid,
  output logic [SEQ_W-1:0] gtail_seq
);

  logic [NTHR-1:0][CNT_W-1:0] cnt_v;
  logic [NTHR-1:0][SEQ_W-1:0] hseq_v, tseq_v;
  logic [NTHR-1:0][PC_W-1:0]  hpc_v;
  logic [NTHR-1:0][WN_W-1:0]  walk_n_v;
  logic [NTHR-1:0]            hsq_v, ins_acc_v, ret_v, ne_v, walk_end_v;
  logic                       sq_live;

  // A squash is only acted on while some entry is held.
  assign sq_live = sq_vld && (tot_cnt != '0);

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    rob_tq #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .PC_W(PC_W), .SQ_W(SQ_W)) u_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .ins_en   (ins_vld && ins_tid == TID_W'(t)),
      .ins_seq  (ins_seq),
      .ins_pc   (ins_pc),
      .cpl_en   (cpl_vld && cpl_tid == TID_W'(t)),
      .cpl_seq  (cpl_seq),
      .cmt_en   (cmt_vld && cmt_tid == TID_W'(t)),
      .sq_en    (sq_live && sq_tid == TID_W'(t)),
      .sq_seq   (sq_seq),
      .cnt      (cnt_v[t]),
      .full     (thr_full[t]),
      .busy     (thr_busy[t]),
      .ins_acc  (ins_acc_v[t]),
      .ret      (ret_v[t]),
      .hd_rdy   (head_rdy[t]),
      .hd_seq   (hseq_v[t]),
      .hd_pc    (hpc_v[t]),
      .hd_sq    (hsq_v[t]),
      .tl_seq   (tseq_v[t]),
      .walk_n   (walk_n_v[t]),
      .walk_end (walk_end_v[t])
    );
    assign ne_v[t] = (cnt_v[t] != '0);
  end

  always_comb begin
    tot_cnt = '0;
    for (int t = 0; t < NTHR; t++) tot_cnt = tot_cnt + TOT_W'(cnt_v[t]);
  end

  assign can_cmt = |head_rdy;
  assign ret_vld = |ret_v;
  assign ret_seq = hseq_v[cmt_tid];
  assign ret_pc  = hpc_v[cmt_tid];
  assign ret_sq  = hsq_v[cmt_tid];

  rob_pick #(.NTHR(NTHR), .SEQ_W(SEQ_W), .TID_W(TID_W)) u_pick (
    .ne    (ne_v),
    .hseq  (hseq_v),
    .tseq  (tseq_v),
    .h_vld (ghead_vld),
    .h_tid (ghead_tid),
    .h_seq (ghead_seq),
    .t_vld (gtail_vld),
    .t_tid (gtail_tid),
    .t_seq (gtail_seq)
  );

endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
  parameter int NTHR  = 2,
  parameter int SQ_W  = 2,
  parameter int WN_W  = 2,
  parameter int TOT_W = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NTHR-1:0]           ins_acc_v,
  input logic [NTHR-1:0]           thr_busy,
  input logic                      ret_vld,
  input logic                      can_cmt,
  input logic [TOT_W-1:0]          tot_cnt,
  input logic                      ghead_vld,
  input logic                      gtail_vld,
  input logic [NTHR-1:0][WN_W-1:0] walk_n_v,
  input logic                      sq_vld
);

  // R2 R5
  cnt_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> int'(tot_cnt) == int'($past(tot_cnt))
      + $countones($past(ins_acc_v)) - int'($past(ret_vld)));

  // R5
  ret_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_vld |-> can_cmt);

  // R3
  busy_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_acc_v & thr_busy) == '0);

  // R9
  ghead_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ghead_vld == (tot_cnt != '0));

  // R9
  gtail_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gtail_vld == (tot_cnt != '0));

  // R6
  sq_empty_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_vld && tot_cnt == '0 && thr_busy == '0) |=> thr_busy == '0);

  for (genvar t = 0; t < NTHR; t++) begin : g_walk
    // R7
    walk_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(walk_n_v[t]) <= SQ_W);
    // R7
    walk_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      walk_n_v[t] != '0 |-> thr_busy[t]);
  end

endmodule

bind thread_rob rob_chk #(.NTHR(NTHR), .SQ_W(SQ_W), .WN_W(WN_W), .TOT_W(TOT_W)) u_chk (.*);

// File: tb/sim_thread_rob.sv
module sim_thread_rob;
  localparam int NTHR = 2, DEPTH = 4, SEQ_W = 8, PC_W = 16, SQ_W = 2;
  localparam int TID_W = 1, TOT_W = $clog2(NTHR * DEPTH + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic rst_n;
  logic ins_vld = 0, cpl_vld = 0, cmt_vld = 0, sq_vld = 0;
  logic [TID_W-1:0] ins_tid = 0, cpl_tid = 0, cmt_tid = 0, sq_tid = 0;
  logic [SEQ_W-1:0] ins_seq = 0, cpl_seq = 0, sq_seq = 0;
  logic [PC_W-1:0]  ins_pc = 0;
  logic [TOT_W-1:0] tot_cnt;
  logic [NTHR-1:0]  thr_full, thr_busy, head_rdy;
  logic can_cmt, ret_vld, ret_sq, ghead_vld, gtail_vld;
  logic [SEQ_W-1:0] ret_seq, ghead_seq, gtail_seq;
  logic [PC_W-1:0]  ret_pc;
  logic [TID_W-1:0] ghead_tid, gtail_tid;

  thread_rob #(.NTHR(NTHR), .DEPTH(DEPTH), .SEQ_W(SEQ_W), .PC_W(PC_W), .SQ_W(SQ_W)) u0 (.*);

  int total = 0, bad = 0;
  typedef struct { int seq; int pc; int sq; } exp_t;
  exp_t exp_q[$];
  exp_t mon_e;

  function automatic int pc_of(int seq);
    return (seq * 4 + 16'h100) % 65536;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_ret(int seq, int sq);
    exp_t e;
    e.seq = seq; e.pc = pc_of(seq); e.sq = sq;
    exp_q.push_back(e);
  endtask

  // Monitor: compare every retirement against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && ret_vld) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R5 unexpected retire actual=%0d expected=none", ret_seq);
      end else begin
        mon_e = exp_q.pop_front();
        chk("R5 retire seq", int'(ret_seq), mon_e.seq);
        chk("R5 retire pc", int'(ret_pc), mon_e.pc);
        chk("R7 retire squashed flag", int'(ret_sq), mon_e.sq);
      end
    end
  end

  task automatic do_ins(int tid, int seq);
    ins_vld = 1; ins_tid = TID_W'(tid); ins_seq = SEQ_W'(seq); ins_pc = PC_W'(pc_of(seq));
    @(posedge clk); #1 ins_vld = 0;
  endtask

  task automatic do_cpl(int tid, int seq);
    cpl_vld = 1; cpl_tid = TID_W'(tid); cpl_seq = SEQ_W'(seq);
    @(posedge clk); #1 cpl_vld = 0;
  endtask

  task automatic do_cmt(int tid, int n);
    cmt_vld = 1; cmt_tid = TID_W'(tid);
    repeat (n) @(posedge clk);
    #1 cmt_vld = 0;
  endtask

  task automatic do_sq(int tid, int seq);
    sq_vld = 1; sq_tid = TID_W'(tid); sq_seq = SEQ_W'(seq);
    @(posedge clk); #1 sq_vld = 0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 tot_cnt", int'(tot_cnt), 0);
    chk("R1 ghead_vld", int'(ghead_vld), 0);
    chk("R1 gtail_vld", int'(gtail_vld), 0);
    chk("R1 can_cmt", int'(can_cmt), 0);
    chk("R1 thr_busy", int'(thr_busy), 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R2 inserts on both threads
    do_ins(0, 10); do_ins(0, 11); do_ins(0, 12);
    do_ins(1, 13); do_ins(1, 14);
    chk("R2 tot_cnt after five inserts", int'(tot_cnt), 5);
    chk("R9 ghead tid", int'(ghead_tid), 0);
    chk("R9 ghead seq", int'(ghead_seq), 10);
    chk("R9 gtail tid", int'(gtail_tid), 1);
    chk("R9 gtail seq", int'(gtail_seq), 14);
    chk("R4 nothing ready", int'(can_cmt), 0);

    // R5 commit of a head that is not ready
    cmt_vld = 1; cmt_tid = 0;
    @(negedge clk);
    chk("R5 no retire when not ready", int'(ret_vld), 0);
    @(posedge clk); #1 cmt_vld = 0;
    chk("R5 count held", int'(tot_cnt), 5);

    // R4 completion of a non-head entry, then of the head
    do_cpl(0, 11);
    chk("R4 head not ready", int'(head_rdy[0]), 0);
    do_cpl(0, 10);
    chk("R4 head ready", int'(head_rdy[0]), 1);
    chk("R4 can_cmt", int'(can_cmt), 1);
    expect_ret(10, 0);
    do_cmt(0, 1);
    chk("R5 count after retire", int'(tot_cnt), 4);
    chk("R9 new ghead seq", int'(ghead_seq), 11);

    // R3 fill thread 1, then an insert into the full queue is dropped
    do_ins(1, 15); do_ins(1, 16);
    chk("R3 thread1 full", int'(thr_full[1]), 1);
    do_ins(1, 17);
    chk("R3 full insert count", int'(tot_cnt), 6);
    chk("R3 full insert gtail", int'(gtail_seq), 16);

    // R7 R8 squash thread 1 above 13: three younger entries, width 2
    do_sq(1, 13);
    chk("R6 busy after request", int'(thr_busy[1]), 1);
    @(posedge clk); #1;
    chk("R7 walk limited to width", int'(thr_busy[1]), 1);
    @(posedge clk); #1;
    chk("R8 walk finished", int'(thr_busy[1]), 0);
    chk("R8 older entry untouched", int'(head_rdy[1]), 0);
    do_cpl(1, 13);
    expect_ret(13, 0); expect_ret(14, 1); expect_ret(15, 1); expect_ret(16, 1);
    do_cmt(1, 4);
    chk("R5 thread1 drained", int'(tot_cnt), 2);

    // Drain thread 0
    do_cpl(0, 12);
    expect_ret(11, 0); expect_ret(12, 0);
    do_cmt(0, 2);
    chk("R9 empty ghead_vld", int'(ghead_vld), 0);
    chk("R9 empty gtail_vld", int'(gtail_vld), 0);

    // R6 squash on an empty buffer
    do_sq(0, 3);
    chk("R6 empty squash ignored", int'(thr_busy), 0);

    // R3 insert blocked during walk (queue wraps here)
    do_ins(0, 20); do_ins(0, 21); do_ins(0, 22);
    do_sq(0, 20);
    chk("R6 busy thread0", int'(thr_busy[0]), 1);
    ins_vld = 1; ins_tid = 0; ins_seq = 30; ins_pc = PC_W'(pc_of(30));
    @(posedge clk); #1 ins_vld = 0;
    chk("R8 short walk finished", int'(thr_busy[0]), 0);
    chk("R3 busy insert dropped count", int'(tot_cnt), 3);
    chk("R3 busy insert dropped gtail", int'(gtail_seq), 22);

    // R10 unsigned ordering
    do_ins(1, 200);
    chk("R10 gtail tid", int'(gtail_tid), 1);
    chk("R10 gtail seq", int'(gtail_seq), 200);
    chk("R10 ghead seq", int'(ghead_seq), 20);
    do_cpl(0, 20);
    expect_ret(20, 0); expect_ret(21, 1); expect_ret(22, 1);
    do_cmt(0, 3);
    chk("R9 ghead other thread", int'(ghead_tid), 1);

    // R8 walk runs off the head
    do_sq(1, 5);
    @(posedge clk); #1;
    chk("R8 walk past head", int'(thr_busy[1]), 0);
    expect_ret(200, 1);
    do_cmt(1, 1);
    chk("R5 all drained", int'(tot_cnt), 0);

    repeat (2) @(posedge clk); #1;
    chk("R5 scoreboard empty", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule